// File: doc/BRIEF.md
# Secondary-processor video-memory window mapper

This block sits between a secondary processor's bus and the video-memory banks. Accesses that fall in the video region `0x06000000` to `0x06FFFFFF` are redirected through two 128 KiB windows. Each window either points at one video-RAM bank page or is empty. A read through an empty window returns zero and a write through it is dropped. Accesses outside that region reach the memory side unchanged.

A configuration port changes the window table. It can bind a bank page to a slot, empty a slot, or empty the whole table at once. Beside the table it keeps a two-bit status register that records which of two particular banks have been handed to the secondary processor.

Each window slot is a small state machine with two states. `SLOT_FREE` means the window is empty. `SLOT_BOUND` means the window holds a page.
- The transition *bind* goes from `SLOT_FREE` to `SLOT_BOUND`, or from `SLOT_BOUND` back to `SLOT_BOUND` with a new page. It happens on an assign to that slot with a page that is not the reserved code.
- The transition *release* goes from `SLOT_BOUND` to `SLOT_FREE`. It happens on a clear of that slot, on unmap-all, or on an assign of the reserved code.

Translation is combinational. The table and the status register are the only state.

Top module: `vram_window_mapper`

## Requirements
- R1: After reset both windows are empty and `bank_status` is 0.
- R2: An address below `0x06000000` or at/above `0x07000000` is passed through as follows:
  - `mem_addr` equals `cpu_addr` and `mem_hit` is 1.
  - `mem_re` and `mem_we` follow `cpu_re` and `cpu_we`.
  - `cpu_rdata` equals `mem_rdata`.
- R3: Inside the region, address bit 17 picks window 0 or 1 and bits 16:0 are the offset. Bits 23:18 are ignored, so the windows repeat through the region.
- R4: A bound window translates to `0x06800000 + (page << 17) + offset`.
- R5: A window is empty in two cases: it was never bound, or it holds the reserved page code 15 (all ones, including when 15 is assigned). An access through an empty window behaves as follows:
  - `mem_hit` is 0 and `mem_addr` is 0.
  - `mem_re` and `mem_we` are 0.
  - `cpu_rdata` is 0.
- R6: An assign binds `cfg_page` to slot 0 or 1. An assign naming any other slot value (2 to 7) leaves both windows unchanged.
- R7: An assign naming bank 2 sets `bank_status` bit 1, and one naming bank 3 sets bit 0. The bit is set whatever the slot value, including a rejected slot. Status bits never clear except through unmap-all.
- R8: A clear empties the named slot and leaves `bank_status` unchanged. A clear and an assign to the same slot in one cycle leave it empty.
- R9: Unmap-all empties both windows and zeroes `bank_status`. It overrides any assign or clear in the same cycle.
- R10: A configuration command applies from the clock edge that samples it. An access in the cycle right after uses the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_assign | input | 1 | Bind `cfg_page` to slot `cfg_slot` |
| cfg_clear | input | 1 | Empty slot `cfg_slot` |
| cfg_unmap_all | input | 1 | Empty every slot and zero the status |
| cfg_slot | input | 3 | Target slot number |
| cfg_bank | input | 4 | Bank index being attached |
| cfg_page | input | 4 | Bank page number, 15 reserved as empty |
| bank_status | output | 2 | Attach flags: bit 1 bank 2, bit 0 bank 3 |
| cpu_addr | input | 32 | Processor address |
| cpu_re | input | 1 | Processor read strobe |
| cpu_we | input | 1 | Processor write strobe |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Read data to processor, zero when empty |
| mem_addr | output | 32 | Translated physical address |
| mem_hit | output | 1 | Access is mapped |
| mem_re | output | 1 | Read strobe to memory, gated |
| mem_we | output | 1 | Write strobe to memory, gated |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data from memory |

## Verification
The bench builds the block with its default parameters: two windows, a 17-bit window offset, a 3-bit slot field and a 4-bit page code. With these values every slot code is reachable, including the six rejected ones, and so is the reserved page code 15. Bits above bit 17 can be set to reach the repeated window images at the top of the region. The region edges `0x05FFFFFF`, `0x06000000` and `0x07000000` are driven directly.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
    typedef enum logic {
        SLOT_FREE  = 1'b0,
        SLOT_BOUND = 1'b1
    } slot_state_t;
endpackage

// File: rtl/vwm_slot_table.sv
module vwm_slot_table
    import vwm_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int SLOT_W  = 3,
    parameter int PAGE_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_assign,
    input  logic                           cfg_clear,
    input  logic                           cfg_unmap_all,
    input  logic [SLOT_W-1:0]              cfg_slot,
    input  logic [PAGE_W-1:0]              cfg_page,
    output logic [NUM_WIN-1:0][PAGE_W-1:0] win_page
);
    localparam logic [PAGE_W-1:0] EMPTY_CODE = {PAGE_W{1'b1}};

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_slot
        slot_state_t       state_q, state_d;
        logic [PAGE_W-1:0] page_q, page_d;
        logic              hit_slot;

        assign hit_slot = (cfg_slot == SLOT_W'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q <= SLOT_FREE;
                page_q  <= EMPTY_CODE;
            end else begin
                state_q <= state_d;
                page_q  <= page_d;
            end
        end

        always_comb begin
            state_d = state_q;
            page_d  = page_q;
            unique case (state_q)
                SLOT_FREE: begin
                    if (!cfg_unmap_all && !(cfg_clear && hit_slot) &&
                        cfg_assign && hit_slot && cfg_page != EMPTY_CODE) begin
                        state_d = SLOT_BOUND;
                        page_d  = cfg_page;
                    end
                end
                SLOT_BOUND: begin
                    if (cfg_unmap_all || (cfg_clear && hit_slot)) begin
                        state_d = SLOT_FREE;
                        page_d  = EMPTY_CODE;
                    end else if (cfg_assign && hit_slot) begin
                        if (cfg_page == EMPTY_CODE) begin
                            state_d = SLOT_FREE;
                            page_d  = EMPTY_CODE;
                        end else begin
                            page_d  = cfg_page;
                        end
                    end
                end
                default: begin
                    state_d = SLOT_FREE;
                    page_d  = EMPTY_CODE;
                end
            endcase
        end

        always_comb begin
            win_page[w] = (state_q == SLOT_BOUND) ? page_q : EMPTY_CODE;
        end
    end

    // R6: an assign to an out-of-range slot leaves the table alone
    p_bad_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_assign && !cfg_clear && !cfg_unmap_all && cfg_slot >= SLOT_W'(NUM_WIN))
        |=> $stable(win_page));

    // R9: unmap-all leaves every window empty
    p_unmap_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_unmap_all |=> (win_page == {NUM_WIN{EMPTY_CODE}}));
endmodule

// File: rtl/vwm_status.sv
module vwm_status #(
    parameter int BANK_W  = 4,
    parameter int BANK_HI = 2,
    parameter int BANK_LO = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_assign,
    input  logic              cfg_unmap_all,
    input  logic [BANK_W-1:0] cfg_bank,
    output logic [1:0]        bank_status
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_status <= 2'b00;
        end else if (cfg_unmap_all) begin
            bank_status <= 2'b00;
        end else if (cfg_assign) begin
            if (cfg_bank == BANK_W'(BANK_HI)) bank_status[1] <= 1'b1;
            if (cfg_bank == BANK_W'(BANK_LO)) bank_status[0] <= 1'b1;
        end
    end

    // R7: status flags only fall through unmap-all
    p_stat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unmap_all |=> ((bank_status & $past(bank_status)) == $past(bank_status)));

    // R9: unmap-all zeroes the flags
    p_stat_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_unmap_all |=> (bank_status == 2'b00));
endmodule

// File: rtl/vwm_xlate.sv
module vwm_xlate #(
    parameter int              ADDR_W      = 32,
    parameter int              DATA_W      = 32,
    parameter int              NUM_WIN     = 2,
    parameter int              WIN_BITS    = 17,
    parameter int              PAGE_W      = 4,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0600_0000,
    parameter logic [ADDR_W-1:0] REGION_SPAN = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h0680_0000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_WIN-1:0][PAGE_W-1:0] win_page,
    input  logic [ADDR_W-1:0]              cpu_addr,
    input  logic                           cpu_re,
    input  logic                           cpu_we,
    output logic [DATA_W-1:0]              cpu_rdata,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic                           mem_hit,
    output logic                           mem_re,
    output logic                           mem_we,
    input  logic [DATA_W-1:0]              mem_rdata
);
    localparam int                SEL_W      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam logic [PAGE_W-1:0] EMPTY_CODE = {PAGE_W{1'b1}};
    localparam logic [ADDR_W-1:0] REGION_END = REGION_BASE + REGION_SPAN;

    logic              in_region;
    logic [SEL_W-1:0]  win_sel;
    logic [PAGE_W-1:0] sel_page;
    logic              sel_empty;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        in_region = (cpu_addr >= REGION_BASE) && (cpu_addr < REGION_END);
        win_sel   = cpu_addr[WIN_BITS +: SEL_W];
        sel_page  = win_page[win_sel];
        sel_empty = (sel_page == EMPTY_CODE);
        offset    = {{(ADDR_W-WIN_BITS){1'b0}}, cpu_addr[WIN_BITS-1:0]};
        mem_hit   = !in_region || !sel_empty;
        if (!in_region)
            mem_addr = cpu_addr;
        else if (sel_empty)
            mem_addr = '0;
        else
            mem_addr = TARGET_BASE + (ADDR_W'(sel_page) << WIN_BITS) + offset;
        mem_re    = cpu_re && mem_hit;
        mem_we    = cpu_we && mem_hit;
        cpu_rdata = mem_hit ? mem_rdata : '0;
    end

    // R2: accesses outside the region reach memory untouched
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < REGION_BASE || cpu_addr >= REGION_END)
        |-> (mem_addr == cpu_addr && mem_we == cpu_we && mem_re == cpu_re));

    // R5: an empty window yields no strobe and zero read data
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_hit |-> (!mem_we && !mem_re && cpu_rdata == '0));
endmodule

// File: rtl/vram_window_mapper.sv
module vram_window_mapper #(
    parameter int              ADDR_W      = 32,
    parameter int              DATA_W      = 32,
    parameter int              NUM_WIN     = 2,
    parameter int              WIN_BITS    = 17,
    parameter int              SLOT_W      = 3,
    parameter int              BANK_W      = 4,
    parameter int              PAGE_W      = 4,
    parameter int              BANK_HI     = 2,
    parameter int              BANK_LO     = 3,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0600_0000,
    parameter logic [ADDR_W-1:0] REGION_SPAN = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h0680_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_assign,
    input  logic              cfg_clear,
    input  logic              cfg_unmap_all,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [PAGE_W-1:0] cfg_page,
    output logic [1:0]        bank_status,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_re,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_hit,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [NUM_WIN-1:0][PAGE_W-1:0] win_page;

    vwm_slot_table #(.NUM_WIN(NUM_WIN), .SLOT_W(SLOT_W), .PAGE_W(PAGE_W)) u_table (
        .clk(clk), .rst_n(rst_n), .cfg_assign(cfg_assign), .cfg_clear(cfg_clear),
        .cfg_unmap_all(cfg_unmap_all), .cfg_slot(cfg_slot), .cfg_page(cfg_page),
        .win_page(win_page)
    );

    vwm_status #(.BANK_W(BANK_W), .BANK_HI(BANK_HI), .BANK_LO(BANK_LO)) u_status (
        .clk(clk), .rst_n(rst_n), .cfg_assign(cfg_assign),
        .cfg_unmap_all(cfg_unmap_all), .cfg_bank(cfg_bank), .bank_status(bank_status)
    );

    vwm_xlate #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS),
        .PAGE_W(PAGE_W), .REGION_BASE(REGION_BASE), .REGION_SPAN(REGION_SPAN),
        .TARGET_BASE(TARGET_BASE)
    ) u_xlate (
        .clk(clk), .rst_n(rst_n), .win_page(win_page), .cpu_addr(cpu_addr),
        .cpu_re(cpu_re), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .mem_addr(mem_addr),
        .mem_hit(mem_hit), .mem_re(mem_re), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    assign mem_wdata = cpu_wdata;

    // R4: every mapped access inside the region lands in the target space
    p_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_hit && cpu_addr >= REGION_BASE && cpu_addr < REGION_BASE + REGION_SPAN)
        |-> (mem_addr >= TARGET_BASE));
endmodule

// File: tb/vram_window_mapper_tb.sv
module vram_window_mapper_tb;
    localparam time CLK_P = 10ns;
    localparam logic [31:0] RDV = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_assign = 1'b0, cfg_clear = 1'b0, cfg_unmap_all = 1'b0;
    logic [2:0]  cfg_slot = '0;
    logic [3:0]  cfg_bank = '0;
    logic [3:0]  cfg_page = '0;
    logic [1:0]  bank_status;
    logic [31:0] cpu_addr = '0;
    logic        cpu_re = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_wdata = 32'h1234_5678;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata;
    logic        mem_hit, mem_re, mem_we;
    logic [31:0] mem_rdata = RDV;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    vram_window_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_assign(cfg_assign), .cfg_clear(cfg_clear),
        .cfg_unmap_all(cfg_unmap_all), .cfg_slot(cfg_slot), .cfg_bank(cfg_bank),
        .cfg_page(cfg_page), .bank_status(bank_status), .cpu_addr(cpu_addr),
        .cpu_re(cpu_re), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .mem_hit(mem_hit), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] xl(input logic [3:0] page, input logic [31:0] a);
        return 32'h0680_0000 + ({28'd0, page} << 17) + {15'd0, a[16:0]};
    endfunction

    task automatic cfg(input logic as, input logic cl, input logic ua,
                       input logic [2:0] slot, input logic [3:0] bank, input logic [3:0] page);
        @(negedge clk);
        cfg_assign = as; cfg_clear = cl; cfg_unmap_all = ua;
        cfg_slot = slot; cfg_bank = bank; cfg_page = page;
        @(negedge clk);
        cfg_assign = 1'b0; cfg_clear = 1'b0; cfg_unmap_all = 1'b0;
    endtask

    task automatic acc(input logic [31:0] a, input logic re, input logic we);
        cpu_addr = a; cpu_re = re; cpu_we = we;
        #1;
    endtask

    task automatic expect_empty(input string req, input logic [31:0] a);
        acc(a, 1'b1, 1'b1);
        chk(req, {31'd0, mem_hit}, 32'd0);
        chk(req, {30'd0, mem_re, mem_we}, 32'd0);
        chk(req, cpu_rdata, 32'd0);
        chk(req, mem_addr, 32'd0);
    endtask

    task automatic expect_map(input string req, input logic [31:0] a, input logic [3:0] page);
        acc(a, 1'b1, 1'b0);
        chk(req, {31'd0, mem_hit}, 32'd1);
        chk(req, mem_addr, xl(page, a));
        chk(req, cpu_rdata, RDV);
    endtask

    task automatic t_reset;
        chk("R1 status", {30'd0, bank_status}, 32'd0);
        expect_empty("R1 win0", 32'h0600_0100);
        expect_empty("R1 win1", 32'h0602_0100);
    endtask

    task automatic t_passthru;
        acc(32'h05FF_FFFF, 1'b0, 1'b1);
        chk("R2 below addr", mem_addr, 32'h05FF_FFFF);
        chk("R2 below we", {31'd0, mem_we}, 32'd1);
        chk("R2 wdata", mem_wdata, cpu_wdata);
        acc(32'h0700_0000, 1'b1, 1'b0);
        chk("R2 top addr", mem_addr, 32'h0700_0000);
        chk("R2 top hit", {31'd0, mem_hit}, 32'd1);
        chk("R2 top rdata", cpu_rdata, RDV);
        chk("R2 top re", {31'd0, mem_re}, 32'd1);
    endtask

    task automatic t_assign_now;
        cfg(1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 4'd5);
        expect_map("R10 R4 win0", 32'h0600_1234, 4'd5);
        chk("R4 literal", mem_addr, 32'h068A_1234);
        expect_map("R4 region base", 32'h0600_0000, 4'd5);
    endtask

    task automatic t_window_sel;
        cfg(1'b1, 1'b0, 1'b0, 3'd1, 4'd1, 4'd9);
        expect_map("R3 win1 edge", 32'h0603_FFFF, 4'd9);
        chk("R3 literal", mem_addr, 32'h0693_FFFF);
        expect_map("R3 mirror win1", 32'h06FE_0010, 4'd9);
        expect_map("R3 mirror win0", 32'h06FC_0010, 4'd5);
    endtask

    task automatic t_bad_slot;
        for (int s = 2; s < 8; s++) begin
            cfg(1'b1, 1'b0, 1'b0, 3'(s), 4'd2, 4'd7);
            expect_map("R6 win0 kept", 32'h0600_0040, 4'd5);
            expect_map("R6 win1 kept", 32'h0602_0040, 4'd9);
        end
        chk("R7 bank2 rejected slot", {30'd0, bank_status}, 32'd2);
        cfg(1'b1, 1'b0, 1'b0, 3'd0, 4'd3, 4'd1);
        chk("R7 bank3", {30'd0, bank_status}, 32'd3);
        expect_map("R6 rebind", 32'h0600_1234, 4'd1);
        cfg(1'b1, 1'b0, 1'b0, 3'd1, 4'd5, 4'd9);
        chk("R7 other bank", {30'd0, bank_status}, 32'd3);
    endtask

    task automatic t_clear;
        cfg(1'b0, 1'b1, 1'b0, 3'd1, 4'd0, 4'd0);
        expect_empty("R8 R5 cleared win1", 32'h0602_0000);
        chk("R8 status kept", {30'd0, bank_status}, 32'd3);
        expect_map("R8 win0 kept", 32'h0600_0008, 4'd1);
        cfg(1'b1, 1'b1, 1'b0, 3'd1, 4'd0, 4'd6);
        expect_empty("R8 clear beats assign", 32'h0602_0000);
        cfg(1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 4'd15);
        expect_empty("R5 reserved code", 32'h0600_0000);
    endtask

    task automatic t_unmap_all;
        cfg(1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 4'd4);
        cfg(1'b1, 1'b0, 1'b0, 3'd1, 4'd0, 4'd8);
        expect_map("R9 pre", 32'h0602_0000, 4'd8);
        cfg(1'b1, 1'b0, 1'b1, 3'd1, 4'd2, 4'd3);
        expect_empty("R9 win0", 32'h0600_0000);
        expect_empty("R9 win1", 32'h0602_0000);
        chk("R9 status", {30'd0, bank_status}, 32'd0);
    endtask

    initial begin : watchdog
        #(CLK_P * 50000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthru();
        t_assign_now();
        t_window_sel();
        t_bad_slot();
        t_clear();
        t_unmap_all();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule